// File: doc/BRIEF.md
# Manchester Fieldbus Receive Framer

This block is the back end of a Manchester receiver. It takes a stream of half-bit levels that have already been sampled and recovered, each qualified by a strobe. It finds the frame start pattern, turns each following group of eight symbols into a byte, and writes the packet into a small receive queue. The ninth bit of each queue word marks a special entry. Special entries mark the start of a packet, the end of a packet and a loss of half-bit alignment, so the host can find frame boundaries in the data it reads and needs no end-of-packet timer.

Two flags watch the queue: one for a programmable fill threshold and one for a full queue. Each flag can drive the interrupt line unless it is masked. A host pops words through a simple read strobe. A receive-active output tells the local transmitter to hold off while a frame is arriving.

Symbols are sent as two half-bits, first half first. Data one is `1,0`, data zero is `0,1`, the high non-data symbol is `1,1` and the low non-data symbol is `0,0`. The start pattern is the symbol run 1, high-ND, low-ND, 1, 0, low-ND, high-ND, 0, which is half-bit word 0xB24D with the earliest half in the MSB. The stop pattern is 1, high-ND, low-ND, high-ND, low-ND, 1, 0, 1, which is 0xB326.

Top module: `mfr_rx_framer`

## Requirements
- R1: In a frame, each complete group of eight data symbols pushes one entry {0, byte}, with the first symbol received in byte bit 7.
- R2: When the last 16 half-bits equal 0xB24D outside a frame, the block pushes 0x14D and opens a frame. Preamble symbols before that point are never pushed.
- R3: In a frame, a group whose 16 half-bits equal 0xB326 pushes 0x126, closes the frame and returns to idle.
- R4: In a frame, any other group that holds a non-data symbol pushes 0x100. Every later symbol is then discarded until the next start pattern, and rx_active stays low during that time.
- R5: rx_active rises at the clock edge that samples the first half-bit whose level differs from the previous one while idle. It falls at the edge that samples the last half-bit of a stop group or a slip group.
- R6: The queue holds 16 entries and gives them back in arrival order. full_flag is high exactly while 16 entries are held. A push made while the queue is full is lost.
- R7: lvl_flag is high while the entry count is at least lvl_thresh. When lvl_thresh is 0, lvl_flag stays low.
- R8: irq is high while (lvl_flag and irq_mask_lvl is 0) or (full_flag and irq_mask_full is 0). It follows mask changes one clock later.
- R9: A rd_en pulse on a non-empty queue pops the oldest entry. That entry appears on rd_data with rd_valid high in the next cycle. A rd_en on an empty queue leaves rd_valid low and changes nothing.
- R10: An entry is counted in lvl_flag and full_flag one clock after the edge that samples the half-bit completing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Strobe qualifying sym_bit |
| sym_bit | input | 1 | Sampled half-bit level |
| rx_active | output | 1 | Frame reception in progress |
| rd_en | input | 1 | Pop request |
| rd_data | output | 9 | Popped entry, marker bit in bit 8 |
| rd_valid | output | 1 | rd_data holds a new entry |
| lvl_thresh | input | 4 | Fill threshold, 0 disables |
| irq_mask_lvl | input | 1 | 1 masks lvl_flag from irq |
| irq_mask_full | input | 1 | 1 masks full_flag from irq |
| lvl_flag | output | 1 | Count at or above threshold |
| full_flag | output | 1 | Queue holds 16 entries |
| irq | output | 1 | Unmasked flag present |

## Verification
Every cycle, the assertions check these properties:
- The queue never counts past its depth.
- A write into a full queue without a pop leaves the count unchanged.
- An empty pop never raises rd_valid.
- irq stays low one clock after both masks are set.
- Each marker push agrees with the frame state: a start marker comes with rx_active high, and a stop or slip marker comes with rx_active low.

Only the bench scenarios can show the rest:
- The byte values and bit order.
- That preamble bytes are not stored.
- Discarding after a slip until the next start pattern.
- The exact entries kept and lost on overflow.

The bench checks these against a behavioural queue model on every clock.

// File: rtl/mfr_pkg.sv
package mfr_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned ENTRY_W = DATA_W + 1;
  localparam int unsigned GROUP_W = 2 * DATA_W;

  localparam logic [GROUP_W-1:0] START_HALVES = 16'hB24D;
  localparam logic [GROUP_W-1:0] STOP_HALVES  = 16'hB326;

  localparam logic [ENTRY_W-1:0] MARK_SOF  = 9'h14D;
  localparam logic [ENTRY_W-1:0] MARK_EOF  = 9'h126;
  localparam logic [ENTRY_W-1:0] MARK_SLIP = 9'h100;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HUNT,
    ST_DATA,
    ST_DISCARD
  } rx_state_t;
endpackage

// File: rtl/mfr_group_decode.sv
module mfr_group_decode
  import mfr_pkg::*;
(
  input  logic [GROUP_W-1:0] halves,
  output logic [DATA_W-1:0]  data_byte,
  output logic               all_data
);
  logic [DATA_W-1:0] pair_ok;

  // pair k occupies halves[2k+1:2k]; the first half gives the bit value
  for (genvar k = 0; k < DATA_W; k++) begin : g_pair
    assign data_byte[k] = halves[2*k+1];
    assign pair_ok[k]   = halves[2*k+1] ^ halves[2*k];
  end

  assign all_data = &pair_ok;
endmodule

// File: rtl/mfr_frame_fsm.sv
module mfr_frame_fsm
  import mfr_pkg::*;
#(
  localparam int unsigned CW = $clog2(GROUP_W)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sym_valid,
  input  logic               sym_bit,
  output logic               push_q,
  output logic [ENTRY_W-1:0] push_data_q,
  output logic               rx_active_q
);
  logic [GROUP_W-1:0] sr_q;
  logic [GROUP_W-1:0] win;
  rx_state_t          st_q;
  logic [CW-1:0]      hcnt_q;
  logic [DATA_W-1:0]  grp_byte;
  logic               grp_ok;

  assign win = {sr_q[GROUP_W-2:0], sym_bit};

  mfr_group_decode u_dec (
    .halves    (win),
    .data_byte (grp_byte),
    .all_data  (grp_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q        <= '0;
      st_q        <= ST_IDLE;
      hcnt_q      <= '0;
      push_q      <= 1'b0;
      push_data_q <= '0;
      rx_active_q <= 1'b0;
    end else begin
      push_q <= 1'b0;
      if (sym_valid) begin
        sr_q <= win;
        case (st_q)
          ST_IDLE: begin
            if (sym_bit != sr_q[0]) begin
              st_q        <= ST_HUNT;
              rx_active_q <= 1'b1;
            end
          end
          ST_HUNT, ST_DISCARD: begin
            if (win == START_HALVES) begin
              st_q        <= ST_DATA;
              hcnt_q      <= '0;
              rx_active_q <= 1'b1;
              push_q      <= 1'b1;
              push_data_q <= MARK_SOF;
            end
          end
          ST_DATA: begin
            if (hcnt_q == CW'(GROUP_W - 1)) begin
              hcnt_q <= '0;
              push_q <= 1'b1;
              if (grp_ok) begin
                push_data_q <= {1'b0, grp_byte};
              end else if (win == STOP_HALVES) begin
                push_data_q <= MARK_EOF;
                st_q        <= ST_IDLE;
                rx_active_q <= 1'b0;
              end else begin
                push_data_q <= MARK_SLIP;
                st_q        <= ST_DISCARD;
                rx_active_q <= 1'b0;
              end
            end else begin
              hcnt_q <= hcnt_q + 1'b1;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  p_data_in_frame_r1: assert property (@(posedge clk) disable iff (rst)
    (push_q && !push_data_q[DATA_W]) |-> rx_active_q);
  p_start_opens_r2: assert property (@(posedge clk) disable iff (rst)
    (push_q && push_data_q == MARK_SOF) |-> rx_active_q);
  p_stop_closes_r3: assert property (@(posedge clk) disable iff (rst)
    (push_q && push_data_q == MARK_EOF) |-> !rx_active_q);
  p_slip_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (push_q && push_data_q == MARK_SLIP) |-> !rx_active_q);
endmodule

// File: rtl/mfr_rx_fifo.sv
module mfr_rx_fifo #(
  parameter  int unsigned DEPTH = 16,
  parameter  int unsigned W     = 9,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] thresh,
  input  logic          mask_lvl,
  input  logic          mask_full,
  output logic [W-1:0]  rd_data_q,
  output logic          rd_valid_q,
  output logic          lvl_flag_q,
  output logic          full_flag_q,
  output logic          irq_q
);
  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wp_q, rp_q;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            wr_ok, rd_ok, lvl_d, full_d;

  assign wr_ok = wr_en && (cnt_q != CNTW'(DEPTH));
  assign rd_ok = rd_en && (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (wr_ok && !rd_ok)      cnt_d = cnt_q + 1'b1;
    else if (!wr_ok && rd_ok) cnt_d = cnt_q - 1'b1;
  end

  assign lvl_d  = (thresh != '0) && (cnt_d >= CNTW'(thresh));
  assign full_d = (cnt_d == CNTW'(DEPTH));

  // storage and output register kept free of reset for RAM inference
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data_q <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q        <= '0;
      rp_q        <= '0;
      cnt_q       <= '0;
      rd_valid_q  <= 1'b0;
      lvl_flag_q  <= 1'b0;
      full_flag_q <= 1'b0;
      irq_q       <= 1'b0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
      cnt_q       <= cnt_d;
      rd_valid_q  <= rd_ok;
      lvl_flag_q  <= lvl_d;
      full_flag_q <= full_d;
      irq_q       <= (lvl_d && !mask_lvl) || (full_d && !mask_full);
    end
  end

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(DEPTH));
  p_full_drops_r6: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNTW'(DEPTH) && wr_en && !rd_en) |=> $stable(cnt_q));
  p_empty_read_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && cnt_q == '0) |=> !rd_valid_q);
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    (mask_lvl && mask_full) |=> !irq_q);
endmodule

// File: rtl/mfr_rx_framer.sv
module mfr_rx_framer
  import mfr_pkg::*;
#(
  parameter  int unsigned DEPTH = 16,
  localparam int unsigned TW    = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sym_valid,
  input  logic               sym_bit,
  output logic               rx_active,
  input  logic               rd_en,
  output logic [ENTRY_W-1:0] rd_data,
  output logic               rd_valid,
  input  logic [TW-1:0]      lvl_thresh,
  input  logic               irq_mask_lvl,
  input  logic               irq_mask_full,
  output logic               lvl_flag,
  output logic               full_flag,
  output logic               irq
);
  logic               push;
  logic [ENTRY_W-1:0] push_data;

  mfr_frame_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sym_valid   (sym_valid),
    .sym_bit     (sym_bit),
    .push_q      (push),
    .push_data_q (push_data),
    .rx_active_q (rx_active)
  );

  mfr_rx_fifo #(
    .DEPTH (DEPTH),
    .W     (ENTRY_W)
  ) u_fifo (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (push),
    .wr_data     (push_data),
    .rd_en       (rd_en),
    .thresh      (lvl_thresh),
    .mask_lvl    (irq_mask_lvl),
    .mask_full   (irq_mask_full),
    .rd_data_q   (rd_data),
    .rd_valid_q  (rd_valid),
    .lvl_flag_q  (lvl_flag),
    .full_flag_q (full_flag),
    .irq_q       (irq)
  );
endmodule

// File: tb/mfr_rx_framer_tb.sv
module mfr_rx_framer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SYM_PH = 2;
  localparam int SYM_NL = 3;

  logic clk = 1'b0;
  logic rst, sym_valid, sym_bit, rd_en;
  logic [3:0] lvl_thresh;
  logic irq_mask_lvl, irq_mask_full;
  logic rx_active, rd_valid, lvl_flag, full_flag, irq;
  logic [8:0] rd_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfr_rx_framer u_dut (
    .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym_bit(sym_bit),
    .rx_active(rx_active), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .lvl_thresh(lvl_thresh),
    .irq_mask_lvl(irq_mask_lvl), .irq_mask_full(irq_mask_full),
    .lvl_flag(lvl_flag), .full_flag(full_flag), .irq(irq)
  );

  // behavioural reference model
  logic [8:0]  mq[$];
  logic [15:0] m_win, w16;
  int          m_st, m_hc;
  logic        m_act, m_pend, m_rv, m_lvl, m_full, m_irq, ok, wasfull, wasempty;
  logic [8:0]  m_pdata, m_rd;
  logic [7:0]  b;

  always @(posedge clk) begin
    if (rst) begin
      mq.delete();
      m_win = '0; m_st = 0; m_hc = 0; m_act = 0; m_pend = 0; m_rv = 0;
      m_lvl = 0; m_full = 0; m_irq = 0;
    end else begin
      wasfull  = (mq.size() == 16);
      wasempty = (mq.size() == 0);
      m_rv = 0;
      if (rd_en && !wasempty) begin m_rd = mq.pop_front(); m_rv = 1; end
      if (m_pend && !wasfull) mq.push_back(m_pdata);
      m_pend = 0;
      if (sym_valid) begin
        w16 = {m_win[14:0], sym_bit};
        if (m_st == 0) begin
          if (sym_bit != m_win[0]) begin m_st = 1; m_act = 1; end
        end else if (m_st == 1 || m_st == 3) begin
          if (w16 == 16'hB24D) begin
            m_st = 2; m_hc = 0; m_act = 1; m_pend = 1; m_pdata = 9'h14D;
          end
        end else begin
          if (m_hc == 15) begin
            m_hc = 0; ok = 1;
            for (int k = 0; k < 8; k++) begin
              if (w16[15-2*k] == w16[14-2*k]) ok = 0;
              b[7-k] = w16[15-2*k];
            end
            m_pend = 1;
            if (ok) m_pdata = {1'b0, b};
            else if (w16 == 16'hB326) begin m_pdata = 9'h126; m_st = 0; m_act = 0; end
            else begin m_pdata = 9'h100; m_st = 3; m_act = 0; end
          end else m_hc = m_hc + 1;
        end
        m_win = w16;
      end
      m_lvl  = (lvl_thresh != 0) && (mq.size() >= lvl_thresh);
      m_full = (mq.size() == 16);
      m_irq  = (m_lvl && !irq_mask_lvl) || (m_full && !irq_mask_full);
    end
  end

  task automatic chk(input string what, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R5 rx_active vs model", {8'h0, rx_active}, {8'h0, m_act});
      chk("R6 full_flag vs model", {8'h0, full_flag}, {8'h0, m_full});
      chk("R7 R10 lvl_flag vs model", {8'h0, lvl_flag}, {8'h0, m_lvl});
      chk("R8 irq vs model", {8'h0, irq}, {8'h0, m_irq});
      chk("R9 rd_valid vs model", {8'h0, rd_valid}, {8'h0, m_rv});
      if (m_rv) chk("R9 rd_data vs model", rd_data, m_rd);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL R10 watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic half(input logic v);
    sym_valid = 1'b1; sym_bit = v;
    @(negedge clk);
    sym_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic sym(input int kind);
    case (kind)
      0: begin half(0); half(1); end
      1: begin half(1); half(0); end
      SYM_PH: begin half(1); half(1); end
      default: begin half(0); half(0); end
    endcase
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) sym(int'(v[i]));
  endtask

  task automatic send_start;
    sym(1); sym(SYM_PH); sym(SYM_NL); sym(1); sym(0); sym(SYM_NL); sym(SYM_PH); sym(0);
  endtask

  task automatic send_stop;
    sym(1); sym(SYM_PH); sym(SYM_NL); sym(SYM_PH); sym(SYM_NL); sym(1); sym(0); sym(1);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) half(0);
  endtask

  task automatic read_exp(input logic [8:0] exp, input string what);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk({what, " rd_valid"}, {8'h0, rd_valid}, 9'h1);
    chk({what, " rd_data"}, rd_data, exp);
  endtask

  initial begin
    rst = 1'b1; sym_valid = 0; sym_bit = 0; rd_en = 0;
    lvl_thresh = 4'd3; irq_mask_lvl = 0; irq_mask_full = 0;
    repeat (4) @(negedge clk);
    chk("R5 reset rx_active", {8'h0, rx_active}, 9'h0);
    chk("R6 reset full_flag", {8'h0, full_flag}, 9'h0);
    chk("R7 reset lvl_flag", {8'h0, lvl_flag}, 9'h0);
    chk("R8 reset irq", {8'h0, irq}, 9'h0);
    chk("R9 reset rd_valid", {8'h0, rd_valid}, 9'h0);
    rst = 1'b0;
    @(negedge clk);

    // basic frame with two preamble bytes
    idle(4);
    send_byte(8'hAA); send_byte(8'hAA);
    chk("R5 active during preamble", {8'h0, rx_active}, 9'h1);
    send_start; send_byte(8'hA5); send_byte(8'h3C); send_stop;
    chk("R3 R5 inactive after stop", {8'h0, rx_active}, 9'h0);
    idle(2);
    chk("R7 level flag at four entries", {8'h0, lvl_flag}, 9'h1);
    chk("R8 irq from level", {8'h0, irq}, 9'h1);
    read_exp(9'h14D, "R2 start marker, preamble skipped");
    read_exp(9'h0A5, "R1 first byte");
    read_exp(9'h03C, "R1 second byte");
    read_exp(9'h126, "R3 stop marker");
    chk("R7 level flag cleared", {8'h0, lvl_flag}, 9'h0);
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R9 empty read", {8'h0, rd_valid}, 9'h0);

    // slip then recovery on next start
    idle(2);
    send_byte(8'hAA); send_start; send_byte(8'h11);
    sym(1); sym(SYM_PH); for (int i = 0; i < 6; i++) sym(0);
    chk("R4 slip drops rx_active", {8'h0, rx_active}, 9'h0);
    send_byte(8'h77);
    chk("R4 discarding stays inactive", {8'h0, rx_active}, 9'h0);
    send_byte(8'hAA); send_start; send_byte(8'h42); send_stop; idle(2);
    read_exp(9'h14D, "R2 start");
    read_exp(9'h011, "R1 byte before slip");
    read_exp(9'h100, "R4 slip marker");
    read_exp(9'h14D, "R4 R2 restart after discard");
    read_exp(9'h042, "R1 byte after restart");
    read_exp(9'h126, "R3 stop");

    // overflow with level flag disabled
    lvl_thresh = 4'd0; irq_mask_lvl = 1'b1;
    idle(2);
    send_byte(8'hAA); send_start;
    for (int i = 0; i < 16; i++) send_byte(8'h10 + 8'(i));
    send_stop; idle(2);
    chk("R6 full flag", {8'h0, full_flag}, 9'h1);
    chk("R7 threshold zero keeps flag low", {8'h0, lvl_flag}, 9'h0);
    chk("R8 irq from full", {8'h0, irq}, 9'h1);
    irq_mask_full = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R8 irq masked", {8'h0, irq}, 9'h0);
    read_exp(9'h14D, "R6 first kept");
    for (int i = 0; i < 15; i++) read_exp(9'h010 + 9'(i), "R6 order kept");
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    chk("R6 R9 overflow entries lost", {8'h0, rd_valid}, 9'h0);
    chk("R6 full flag cleared", {8'h0, full_flag}, 9'h0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule